// File: doc/BRIEF.md
# Sequential Max-Min Rule Inference Engine

This block is the inference stage of a two-input fuzzy controller. A fuzzifier upstream describes each crisp input (an error and its rate of change) by the two linguistic terms it overlaps, each with a membership grade. When `start` is pulsed, the engine captures those four (term, grade) pairs and forms the four rules that pair one error term with one rate term. A computed rule table gives each rule's consequent term. The rule's firing strength is the smaller of its two grades. Rules that share a consequent are merged by keeping the larger strength.

All compare work runs on one magnitude comparator. An operand multiplexer and a decoded write select feed it and store its result, one operation per cycle. Four cycles of minimum operations fill the firing registers. Four cycles of maximum operations then fold them into one strength register per consequent term. The per-term strengths and a `done` flag go to the defuzzifier.

Top module: `fz_maxmin_infer`

## Requirements
- R1: After reset every consequent strength is zero and `done` is low.
- R2: A `start` sampled high while idle captures all four input pairs. `done` goes high exactly eight clock edges after the capturing edge and stays high until the next accepted `start`.
- R3: Rule k (k = 0..3) pairs error input `b` if bit 1 of k is set, else `a`, with rate input `b` if bit 0 of k is set, else `a`. Its firing strength is the minimum of the two grades.
- R4: With the default table (RULE_KIND = 0), the consequent term of a rule is floor((error_term + rate_term) / 2).
- R5: When several rules share a consequent, that term's strength is the maximum of their firing strengths.
- R6: All consequent strengths are cleared on the edge that accepts `start`, so no result of an earlier inference survives into the next one.
- R7: A rule whose firing strength is zero leaves every strength register unchanged.
- R8: A `start` that arrives while an inference is running is ignored. Neither the timing of `done` nor the result changes.
- R9: A term that is the consequent of no rule reads zero when `done` is high.
- R10: Grades at the top of their range (all ones) pass through the min and max operations without loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an inference; accepted only when idle |
| e_term_a | input | TERM_W | First error term index |
| e_grade_a | input | GRADE_W | Grade of first error term |
| e_term_b | input | TERM_W | Second error term index |
| e_grade_b | input | GRADE_W | Grade of second error term |
| de_term_a | input | TERM_W | First rate term index |
| de_grade_a | input | GRADE_W | Grade of first rate term |
| de_term_b | input | TERM_W | Second rate term index |
| de_grade_b | input | GRADE_W | Grade of second rate term |
| strength | output | 2**TERM_W * GRADE_W | Per-consequent strength; term t occupies bits [t*GRADE_W +: GRADE_W] |
| done | output | 1 | Result valid; held until the next accepted start |

## Verification
If the step counter or the operand multiplexer is wrong, a firing lands in the wrong register or under the wrong grade. That error shows at `strength` in the same cycle in which `done` rises. A wrong clear or merge shows as a stale or smaller value in one term's slice, and a wrong sequencer shows as `done` rising one edge early or late. Each scenario therefore checks `done` one edge before and exactly at its expected edge, and compares every term slice against a model built from the rule statements.

// File: rtl/fz_inf_pkg.sv
package fz_inf_pkg;
   typedef enum logic [1:0] {PH_IDLE, PH_MIN, PH_MAX} phase_t;

   // Consequent index for an (error, rate) term pair.
   function automatic int unsigned rule_cons(input int unsigned e, input int unsigned de,
                                             input int unsigned nterms, input int unsigned kind);
      if (kind == 0) return (e + de) / 2;
      else           return (e + (nterms - 1 - de)) / 2;
   endfunction
endpackage

// File: rtl/fz_rule_rom.sv
module fz_rule_rom #(
   parameter int TERM_W    = 3,
   parameter int RULE_KIND = 0
) (
   input  logic [TERM_W-1:0] e_term,
   input  logic [TERM_W-1:0] de_term,
   output logic [TERM_W-1:0] cons_term
);
   import fz_inf_pkg::*;
   localparam int NT    = 1 << TERM_W;
   localparam int DEPTH = NT * NT;

   logic [TERM_W-1:0] table_q [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_entry
      assign table_q[i] = TERM_W'(rule_cons(i / NT, i % NT, NT, RULE_KIND));
   end

   assign cons_term = table_q[{e_term, de_term}];
endmodule

// File: rtl/fz_shared_cmp.sv
module fz_shared_cmp #(
   parameter int W = 8
) (
   input  logic         pick_min,
   input  logic [W-1:0] op_a,
   input  logic [W-1:0] op_b,
   output logic [W-1:0] result
);
   logic a_lt_b;
   assign a_lt_b = op_a < op_b;
   assign result = pick_min ? (a_lt_b ? op_a : op_b) : (a_lt_b ? op_b : op_a);
endmodule

// File: rtl/fz_seq_ctrl.sv
module fz_seq_ctrl (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   output fz_inf_pkg::phase_t    phase,
   output logic [1:0]            rule_idx,
   output logic                  accept,
   output logic                  done
);
   import fz_inf_pkg::*;
   localparam logic [2:0] LAST = 3'd7;

   logic [2:0] step_q;
   logic       busy_q;

   assign accept   = !busy_q && start;
   assign rule_idx = step_q[1:0];
   assign phase    = !busy_q ? PH_IDLE : (step_q[2] ? PH_MAX : PH_MIN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q <= '0;
         busy_q <= 1'b0;
         done   <= 1'b0;
      end else if (accept) begin
         step_q <= '0;
         busy_q <= 1'b1;
         done   <= 1'b0;
      end else if (busy_q) begin
         if (step_q == LAST) begin
            busy_q <= 1'b0;
            done   <= 1'b1;
         end else begin
            step_q <= step_q + 3'd1;
         end
      end
   end

   assert_done_after_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> ($past(step_q) == LAST && $past(busy_q)));

   assert_ignore_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && step_q != LAST) |=> (busy_q && step_q == $past(step_q) + 3'd1));
endmodule

// File: rtl/fz_maxmin_infer.sv
module fz_maxmin_infer #(
   parameter int TERM_W    = 3,
   parameter int GRADE_W   = 8,
   parameter int RULE_KIND = 0,
   localparam int NT       = 1 << TERM_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [TERM_W-1:0]     e_term_a,
   input  logic [GRADE_W-1:0]    e_grade_a,
   input  logic [TERM_W-1:0]     e_term_b,
   input  logic [GRADE_W-1:0]    e_grade_b,
   input  logic [TERM_W-1:0]     de_term_a,
   input  logic [GRADE_W-1:0]    de_grade_a,
   input  logic [TERM_W-1:0]     de_term_b,
   input  logic [GRADE_W-1:0]    de_grade_b,
   output logic [NT*GRADE_W-1:0] strength,
   output logic                  done
);
   import fz_inf_pkg::*;
   localparam int NRULES = 4;

   if (TERM_W < 1 || TERM_W > 4) begin : g_bad_term
      $error("TERM_W must be 1..4");
   end
   if (GRADE_W < 2 || GRADE_W > 16) begin : g_bad_grade
      $error("GRADE_W must be 2..16");
   end
   if (RULE_KIND < 0 || RULE_KIND > 1) begin : g_bad_kind
      $error("RULE_KIND must be 0 or 1");
   end

   phase_t     phase;
   logic [1:0] idx;
   logic       accept;

   fz_seq_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start),
      .phase(phase), .rule_idx(idx), .accept(accept), .done(done)
   );

   // Captured fuzzifier outputs, index 0 = a, 1 = b
   logic [1:0][TERM_W-1:0]  e_term_q, de_term_q;
   logic [1:0][GRADE_W-1:0] e_grade_q, de_grade_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         e_term_q   <= '0;
         de_term_q  <= '0;
         e_grade_q  <= '0;
         de_grade_q <= '0;
      end else if (accept) begin
         e_term_q   <= {e_term_b, e_term_a};
         de_term_q  <= {de_term_b, de_term_a};
         e_grade_q  <= {e_grade_b, e_grade_a};
         de_grade_q <= {de_grade_b, de_grade_a};
      end
   end

   // Rule table lookup for the rule currently being processed
   logic [TERM_W-1:0] cons;
   fz_rule_rom #(.TERM_W(TERM_W), .RULE_KIND(RULE_KIND)) u_rom (
      .e_term(e_term_q[idx[1]]), .de_term(de_term_q[idx[0]]), .cons_term(cons)
   );

   logic [NRULES-1:0][GRADE_W-1:0] fire_q;
   logic [NT-1:0][GRADE_W-1:0]     str_q;
   logic [GRADE_W-1:0] fire_cur, str_cur, op_a, op_b, cmp_y;
   logic               pick_min;

   assign fire_cur = fire_q[idx];
   assign str_cur  = str_q[cons];
   assign pick_min = (phase == PH_MIN);
   assign op_a     = pick_min ? e_grade_q[idx[1]]  : fire_cur;
   assign op_b     = pick_min ? de_grade_q[idx[0]] : str_cur;

   fz_shared_cmp #(.W(GRADE_W)) u_cmp (
      .pick_min(pick_min), .op_a(op_a), .op_b(op_b), .result(cmp_y)
   );

   // Firing registers, write select decoded from the rule index
   for (genvar k = 0; k < NRULES; k++) begin : g_fire
      logic we;
      assign we = (phase == PH_MIN) && (idx == 2'(k));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      fire_q[k] <= '0;
         else if (accept) fire_q[k] <= '0;
         else if (we)     fire_q[k] <= cmp_y;
      end
   end

   // Consequent strength registers, write select decoded from the table output
   for (genvar t = 0; t < NT; t++) begin : g_str
      logic we;
      assign we = (phase == PH_MAX) && (fire_cur != '0) && (cons == TERM_W'(t));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      str_q[t] <= '0;
         else if (accept) str_q[t] <= '0;
         else if (we)     str_q[t] <= cmp_y;
      end
   end

   assign strength = str_q;

   assert_min_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_MIN) |-> (cmp_y <= op_a && cmp_y <= op_b && (cmp_y == op_a || cmp_y == op_b)));

   assert_merge_max_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_MAX && fire_cur != '0) |=>
         (str_q[$past(cons)] >= $past(fire_cur) && str_q[$past(cons)] >= $past(str_cur)));

   assert_zero_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_MAX && fire_cur == '0) |=> (str_q == $past(str_q)));

   assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (str_q == '0 && !done));
endmodule

// File: tb/fz_maxmin_infer_test.sv
`timescale 1ns/1ps
module fz_maxmin_infer_test;
   localparam int TERM_W = 3;
   localparam int GW     = 8;
   localparam int NT     = 1 << TERM_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [TERM_W-1:0] eta = '0, etb = '0, dta = '0, dtb = '0;
   logic [GW-1:0]     ega = '0, egb = '0, dga = '0, dgb = '0;
   logic [NT*GW-1:0]  strength;
   logic              done;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   fz_maxmin_infer uut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .e_term_a(eta), .e_grade_a(ega), .e_term_b(etb), .e_grade_b(egb),
      .de_term_a(dta), .de_grade_a(dga), .de_term_b(dtb), .de_grade_b(dgb),
      .strength(strength), .done(done)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Model taken from R3, R4, R5, R7
   task automatic expect_model(input int et[2], input int eg[2], input int dt[2], input int dg[2],
                               output int exp_s[NT]);
      for (int t = 0; t < NT; t++) exp_s[t] = 0;
      for (int k = 0; k < 4; k++) begin
         int g1 = eg[k >> 1];
         int g2 = dg[k & 1];
         int f  = (g1 < g2) ? g1 : g2;
         int c  = (et[k >> 1] + dt[k & 1]) / 2;
         if (f > exp_s[c]) exp_s[c] = f;
      end
   endtask

   task automatic drive(input int et[2], input int eg[2], input int dt[2], input int dg[2]);
      eta = TERM_W'(et[0]); etb = TERM_W'(et[1]);
      dta = TERM_W'(dt[0]); dtb = TERM_W'(dt[1]);
      ega = GW'(eg[0]); egb = GW'(eg[1]);
      dga = GW'(dg[0]); dgb = GW'(dg[1]);
   endtask

   task automatic cmp_all(input int exp_s[NT], input string req);
      for (int t = 0; t < NT; t++)
         chk(strength[t*GW +: GW] == GW'(exp_s[t]), req, int'(strength[t*GW +: GW]), exp_s[t]);
   endtask

   // Start one inference, check done timing (R2) and every strength slice
   task automatic run(input int et[2], input int eg[2], input int dt[2], input int dg[2],
                      input string req);
      int exp_s[NT];
      expect_model(et, eg, dt, dg, exp_s);
      @(negedge clk);
      drive(et, eg, dt, dg);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(done == 1'b0, "R2 done low after accept", int'(done), 0);
      repeat (7) @(negedge clk);
      chk(done == 1'b0, "R2 done not early", int'(done), 0);
      @(negedge clk);
      chk(done == 1'b1, "R2 done at eighth edge", int'(done), 1);
      cmp_all(exp_s, req);
   endtask

   task automatic t_reset();
      chk(done == 1'b0, "R1 done after reset", int'(done), 0);
      chk(strength == '0, "R1 strengths after reset", int'(strength[31:0]), 0);
   endtask

   task automatic t_merge();
      // rules -> cons 0, 3, 3, 7; term 3 merges 200 and 50
      run('{0, 7}, '{200, 50}, '{0, 7}, '{90, 255}, "R3 R4 R5 merge");
      chk(strength[3*GW +: GW] == 8'd200, "R5 max of shared consequent",
          int'(strength[3*GW +: GW]), 200);
      chk(strength[1*GW +: GW] == 8'd0, "R9 unused term zero", int'(strength[1*GW +: GW]), 0);
      repeat (3) @(negedge clk);
      chk(done == 1'b1, "R2 done held", int'(done), 1);
   endtask

   task automatic t_zero();
      // rules 0 and 1 have zero strength, consequents 6 and 4
      run('{6, 2}, '{0, 100}, '{6, 2}, '{120, 30}, "R7 zero firing");
      chk(strength[6*GW +: GW] == 8'd0, "R7 zero rule leaves term", int'(strength[6*GW +: GW]), 0);
      chk(strength[4*GW +: GW] == 8'd100, "R7 zero does not win merge",
          int'(strength[4*GW +: GW]), 100);
   endtask

   task automatic t_clear();
      run('{7, 7}, '{180, 180}, '{7, 7}, '{180, 180}, "R6 setup");
      run('{0, 1}, '{10, 20}, '{0, 1}, '{30, 40}, "R6 cleared between runs");
      chk(strength[7*GW +: GW] == 8'd0, "R6 old term cleared", int'(strength[7*GW +: GW]), 0);
   endtask

   task automatic t_busy_start();
      int exp_s[NT];
      expect_model('{2, 5}, '{77, 150}, '{3, 4}, '{99, 60}, exp_s);
      @(negedge clk);
      drive('{2, 5}, '{77, 150}, '{3, 4}, '{99, 60});
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
      drive('{7, 7}, '{255, 255}, '{7, 7}, '{255, 255});
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
      chk(done == 1'b0, "R8 done not early", int'(done), 0);
      @(negedge clk);
      chk(done == 1'b1, "R8 done at original time", int'(done), 1);
      cmp_all(exp_s, "R8 busy start ignored");
   endtask

   task automatic t_full_scale();
      run('{3, 3}, '{255, 255}, '{4, 4}, '{255, 255}, "R10 full scale grades");
      chk(strength[3*GW +: GW] == 8'd255, "R10 all ones kept", int'(strength[3*GW +: GW]), 255);
   endtask

   task automatic t_sweep();
      logic [15:0] lfsr = 16'hACE1;
      for (int n = 0; n < 20; n++) begin
         int et[2], eg[2], dt[2], dg[2];
         for (int j = 0; j < 2; j++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            et[j] = int'(lfsr[2:0]);
            dt[j] = int'(lfsr[5:3]);
            eg[j] = int'(lfsr[15:8]);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            dg[j] = int'(lfsr[7:0]);
         end
         run(et, eg, dt, dg, "R3 R4 R5 sweep");
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_merge();
      t_zero();
      t_clear();
      t_busy_start();
      t_full_scale();
      t_sweep();
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !finished) begin
         finished = 1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual %0d expected %0d", cycles, 20000);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule